// File: doc/BRIEF.md
# Serial Panel Power-Up Sequencer

This block brings a small TFT panel controller out of power-up and into a displaying state over a three-wire serial link made of select, clock and data. After a start request it pulls the panel's reset pin low for a fixed time and releases it. It waits for the controller to settle, then sends the wake-from-sleep command. A second wait follows, after which a fixed configuration script is played out from an internal ROM. Every byte leaves as a 9-bit word. The top bit of the word tells the panel whether the low eight bits are an opcode or an argument.

Once the script has finished, the block raises `done` and then serves three one-word requests: display on, display off, and enter sleep. The sleep request ends the session. `done` falls, and only a new start can bring the panel back. All waits are counted in milliseconds from a clocks-per-millisecond parameter, so a bench can shrink them. The internal hand-off between the sequencer and the serial shifter is valid/ready. The sequencer holds a word until the shifter accepts it and does not offer the next word until the shifter reports the previous one finished, so there is never more than one word in flight. All control and status pins are plain levels or one-cycle pulses.

Top module: `lcd_init_seq`

## Requirements
- R1: While and after reset, with no start request: `lcd_cs_n`=1, `lcd_sclk`=0, `lcd_rst_n`=1, `busy`=0, `done`=0, and no word is sent.
- R2: A start pulse while idle drives `lcd_rst_n` low for exactly RST_PULSE_MS*CLKS_PER_MS clock cycles. No word is sent during that time. At least RST_SETTLE_MS*CLKS_PER_MS cycles pass from the release of `lcd_rst_n` to the fall of `lcd_cs_n` for the first word.
- R3: Each word is 9 bits and is shifted most significant bit first. Bit 8 is 0 for an opcode and 1 for an argument; bits 7..0 hold the byte. `lcd_sdo` changes only while `lcd_sclk` is low, and the panel samples it on the rising edge. `lcd_cs_n` stays low for all 9 clocks of a word and returns high between words.
- R4: The first word after the reset phase is 0x011 (wake from sleep). At least WAKE_MS*CLKS_PER_MS cycles pass from the rise of `lcd_cs_n` after that word to the next fall of `lcd_cs_n`.
- R5: The script then sends these 28 words, in this order: 036 100, 03A 166, 0B2 10C 10C 100 133 133, 0B7 135, 0BB 12B, 0C3 10F, 0C4 120, 0C6 10F, 0D0 1A4 1A1, 021, 0B1 1CE 108 114.
- R6: After the last script word, `done` goes to 1 and `busy` goes to 0. `busy` is 1 from the start pulse until then.
- R7: Enable, disable and shutdown pulses are ignored until `done` is 1 and while any word is in progress. A start pulse is ignored unless the block is idle with `done`=0. Ignored pulses send no word.
- R8: When `done`=1 and the block is not busy, an enable pulse sends only the word 0x029 and a disable pulse sends only 0x028. `done` stays 1 after either.
- R9: A shutdown pulse in the same state sends only 0x010. After that word `done` falls to 0, later enable pulses send nothing, and a new start repeats the whole power-up sequence.
- R10: When several requests arrive in the same cycle, shutdown wins over disable, and disable wins over enable. Exactly one word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: begin the power-up sequence |
| en_req | input | 1 | Pulse: send display-on |
| dis_req | input | 1 | Pulse: send display-off |
| off_req | input | 1 | Pulse: send sleep-enter and end the session |
| lcd_cs_n | output | 1 | Serial chip select, active low |
| lcd_sclk | output | 1 | Serial clock, idles low |
| lcd_sdo | output | 1 | Serial data to the panel |
| lcd_rst_n | output | 1 | Panel reset, active low |
| busy | output | 1 | Sequence or request in progress |
| done | output | 1 | Initialisation complete |

## Verification
The bench decodes every word from the pins. The full power-up run is compared word by word against an expected table, which tells a wrong ROM entry or order apart from a framing error, and framing is checked separately through bit counts and data edges. The reset pulse length and the two waits are measured in clock cycles, so a shortened or skipped delay shows up on its own. Requests are sent before start, during initialisation, one at a time after `done`, in coincident pairs and triples, and after shutdown. Each case separates correct gating and priority from a word that is missing or extra. A second start after shutdown shows that the sequence restarts cleanly.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int WORD_W = 9;
  localparam int SCRIPT_LEN = 28;

  localparam logic [7:0] OP_SLEEP_IN  = 8'h10;
  localparam logic [7:0] OP_SLEEP_OUT = 8'h11;
  localparam logic [7:0] OP_INVERT_ON = 8'h21;
  localparam logic [7:0] OP_DISP_OFF  = 8'h28;
  localparam logic [7:0] OP_DISP_ON   = 8'h29;
  localparam logic [7:0] OP_ADDR_MODE = 8'h36;
  localparam logic [7:0] OP_PIX_FMT   = 8'h3A;

  typedef struct packed {
    logic       is_arg;
    logic       last;
    logic [7:0] val;
  } rom_ent_t;

  typedef enum logic [2:0] {
    S_OFF, S_RST, S_SETTLE, S_WAKE, S_WAKE_WAIT, S_SCRIPT, S_READY, S_CMD
  } seq_st_t;

endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_seq_pkg::*;
#(
  parameter int LEN = SCRIPT_LEN,
  localparam int AW = $clog2(LEN)
) (
  input  logic [AW-1:0] idx,
  output rom_ent_t      ent
);

  function automatic rom_ent_t op(input logic [7:0] b);
    return '{is_arg: 1'b0, last: 1'b0, val: b};
  endfunction

  function automatic rom_ent_t arg(input logic [7:0] b);
    return '{is_arg: 1'b1, last: 1'b0, val: b};
  endfunction

  always_comb begin
    ent = '{is_arg: 1'b0, last: 1'b1, val: 8'h00};
    case (idx)
      AW'(0):  ent = op(OP_ADDR_MODE);
      AW'(1):  ent = arg(8'h00);
      AW'(2):  ent = op(OP_PIX_FMT);
      AW'(3):  ent = arg({4'd6, 4'd6});
      AW'(4):  ent = op(8'hB2);
      AW'(5):  ent = arg(8'h0C);
      AW'(6):  ent = arg(8'h0C);
      AW'(7):  ent = arg(8'h00);
      AW'(8):  ent = arg({4'd3, 4'd3});
      AW'(9):  ent = arg({4'd3, 4'd3});
      AW'(10): ent = op(8'hB7);
      AW'(11): ent = arg({1'b0, 3'd3, 1'b0, 3'd5});
      AW'(12): ent = op(8'hBB);
      AW'(13): ent = arg(8'h2B);
      AW'(14): ent = op(8'hC3);
      AW'(15): ent = arg(8'h0F);
      AW'(16): ent = op(8'hC4);
      AW'(17): ent = arg(8'h20);
      AW'(18): ent = op(8'hC6);
      AW'(19): ent = arg(8'h0F);
      AW'(20): ent = op(8'hD0);
      AW'(21): ent = arg(8'hA4);
      AW'(22): ent = arg({2'd2, 2'd2, 2'd0, 2'd1});
      AW'(23): ent = op(OP_INVERT_ON);
      AW'(24): ent = op(8'hB1);
      AW'(25): ent = arg({1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
      AW'(26): ent = arg({1'b0, 7'd8});
      AW'(27): begin
        ent = arg({3'd0, 5'd20});
        ent.last = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcd_word_tx.sv
module lcd_word_tx #(
  parameter int WORD_W    = 9,
  parameter int HALF_CLKS = 4,
  localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1,
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              word_done,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo
);

  typedef enum logic [1:0] {T_IDLE, T_LOW, T_HIGH, T_GAP} tx_st_t;

  tx_st_t            st_q;
  logic [HW-1:0]     ph_q;
  logic [BW-1:0]     left_q;
  logic [WORD_W-1:0] sh_q;
  logic              cs_q, sclk_q, done_q;
  logic              ph_end;

  assign ph_end = (ph_q == HW'(HALF_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      ph_q   <= '0;
      left_q <= '0;
      sh_q   <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ph_q   <= ph_end ? '0 : ph_q + 1'b1;
      case (st_q)
        T_IDLE: begin
          ph_q <= '0;
          if (in_valid) begin
            sh_q   <= in_word;
            cs_q   <= 1'b0;
            left_q <= BW'(WORD_W - 1);
            st_q   <= T_LOW;
          end
        end
        T_LOW: if (ph_end) begin
          sclk_q <= 1'b1;
          st_q   <= T_HIGH;
        end
        T_HIGH: if (ph_end) begin
          sclk_q <= 1'b0;
          if (left_q == '0) begin
            cs_q <= 1'b1;
            st_q <= T_GAP;
          end else begin
            left_q <= left_q - 1'b1;
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
            st_q   <= T_LOW;
          end
        end
        T_GAP: if (ph_end) begin
          done_q <= 1'b1;
          st_q   <= T_IDLE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == T_IDLE);
  assign word_done = done_q;
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign sdo       = sh_q[WORD_W-1];

  p_sdo_still_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sh_q[WORD_W-1]));
  p_clock_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter int CLKS_PER_MS   = 100000,
  parameter int RST_PULSE_MS  = 30,
  parameter int RST_SETTLE_MS = 120,
  parameter int WAKE_MS       = 120,
  parameter int SCLK_HALF     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic en_req,
  input  logic dis_req,
  input  logic off_req,
  output logic lcd_cs_n,
  output logic lcd_sclk,
  output logic lcd_sdo,
  output logic lcd_rst_n,
  output logic busy,
  output logic done
);

  localparam int RST_CYC    = RST_PULSE_MS * CLKS_PER_MS;
  localparam int SETTLE_CYC = RST_SETTLE_MS * CLKS_PER_MS;
  localparam int WAKE_CYC   = WAKE_MS * CLKS_PER_MS;
  localparam int MAX_A      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_CYC    = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam int AW         = $clog2(SCRIPT_LEN);

  seq_st_t          st_q;
  logic [AW-1:0]    idx_q;
  logic [7:0]       cmd_q;
  logic             issued_q, done_q;
  rom_ent_t         rom_ent;
  logic             tm_load, tm_exp;
  logic [TW-1:0]    tm_len;
  logic             sending, tx_valid, tx_ready, word_done;
  logic [WORD_W-1:0] tx_word;

  lcd_init_rom #(.LEN(SCRIPT_LEN)) u_rom (
    .idx (idx_q),
    .ent (rom_ent)
  );

  lcd_wait_timer #(.CNT_W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_len),
    .expired  (tm_exp)
  );

  lcd_word_tx #(.WORD_W(WORD_W), .HALF_CLKS(SCLK_HALF)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .in_word   (tx_word),
    .word_done (word_done),
    .cs_n      (lcd_cs_n),
    .sclk      (lcd_sclk),
    .sdo       (lcd_sdo)
  );

  always_comb begin
    tm_load = 1'b0;
    tm_len  = '0;
    case (st_q)
      S_OFF:    if (start) begin tm_load = 1'b1; tm_len = TW'(RST_CYC - 1); end
      S_RST:    if (tm_exp) begin tm_load = 1'b1; tm_len = TW'(SETTLE_CYC - 1); end
      S_WAKE:   if (word_done) begin tm_load = 1'b1; tm_len = TW'(WAKE_CYC - 1); end
      default: ;
    endcase
  end

  always_comb begin
    case (st_q)
      S_WAKE:   tx_word = {1'b0, OP_SLEEP_OUT};
      S_SCRIPT: tx_word = {rom_ent.is_arg, rom_ent.val};
      default:  tx_word = {1'b0, cmd_q};
    endcase
  end

  assign sending  = (st_q == S_WAKE) || (st_q == S_SCRIPT) || (st_q == S_CMD);
  assign tx_valid = sending && !issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_OFF;
      idx_q    <= '0;
      cmd_q    <= OP_DISP_ON;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) issued_q <= 1'b1;
      if (word_done)            issued_q <= 1'b0;
      case (st_q)
        S_OFF:    if (start) st_q <= S_RST;
        S_RST:    if (tm_exp) st_q <= S_SETTLE;
        S_SETTLE: if (tm_exp) st_q <= S_WAKE;
        S_WAKE:   if (word_done) st_q <= S_WAKE_WAIT;
        S_WAKE_WAIT: if (tm_exp) begin
          idx_q <= '0;
          st_q  <= S_SCRIPT;
        end
        S_SCRIPT: if (word_done) begin
          if (rom_ent.last) begin
            done_q <= 1'b1;
            st_q   <= S_READY;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_READY: begin
          if (off_req) begin
            cmd_q <= OP_SLEEP_IN;
            st_q  <= S_CMD;
          end else if (dis_req) begin
            cmd_q <= OP_DISP_OFF;
            st_q  <= S_CMD;
          end else if (en_req) begin
            cmd_q <= OP_DISP_ON;
            st_q  <= S_CMD;
          end
        end
        S_CMD: if (word_done) begin
          if (cmd_q == OP_SLEEP_IN) begin
            done_q <= 1'b0;
            st_q   <= S_OFF;
          end else begin
            st_q <= S_READY;
          end
        end
        default: st_q <= S_OFF;
      endcase
    end
  end

  assign lcd_rst_n = (st_q != S_RST);
  assign busy      = (st_q != S_OFF) && (st_q != S_READY);
  assign done      = done_q;

  p_quiet_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> lcd_cs_n);
  p_request_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CMD) |-> done_q);
  p_script_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SCRIPT) |-> (idx_q < AW'(SCRIPT_LEN)));
  p_done_drop_on_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> ($past(cmd_q) == OP_SLEEP_IN));
  p_single_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_q && !word_done) |=> !(tx_valid && tx_ready));

endmodule

// File: tb/lcd_init_seq_tb.sv
module lcd_init_seq_tb;

  localparam int CPM   = 4;
  localparam int NPULS = 30 * CPM;
  localparam int NSETT = 120 * CPM;
  localparam int NWAKE = 120 * CPM;
  localparam int NINIT = 29;

  localparam logic [8:0] EXP [0:NINIT-1] = '{
    9'h011, 9'h036, 9'h100, 9'h03A, 9'h166, 9'h0B2, 9'h10C, 9'h10C,
    9'h100, 9'h133, 9'h133, 9'h0B7, 9'h135, 9'h0BB, 9'h12B, 9'h0C3,
    9'h10F, 9'h0C4, 9'h120, 9'h0C6, 9'h10F, 9'h0D0, 9'h1A4, 9'h1A1,
    9'h021, 9'h0B1, 9'h1CE, 9'h108, 9'h114};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, en_req = 1'b0, dis_req = 1'b0, off_req = 1'b0;
  logic lcd_cs_n, lcd_sclk, lcd_sdo, lcd_rst_n, busy, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lcd_init_seq #(
    .CLKS_PER_MS (CPM),
    .SCLK_HALF   (2)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .en_req (en_req),
    .dis_req (dis_req), .off_req (off_req), .lcd_cs_n (lcd_cs_n),
    .lcd_sclk (lcd_sclk), .lcd_sdo (lcd_sdo), .lcd_rst_n (lcd_rst_n),
    .busy (busy), .done (done)
  );

  // pin monitor
  int         cyc = 0;
  int         nw = 0;
  logic [8:0] w_val [0:127];
  int         w_bits [0:127];
  int         w_fall [0:127];
  int         w_rise [0:127];
  logic [8:0] shreg = '0;
  int         nbits = 0;
  logic       p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_rst = 1'b1;
  int         rst_low = 0, last_rst_len = 0, t_rst_rise = 0, edge_bad = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!lcd_rst_n) rst_low <= rst_low + 1;
    if (lcd_rst_n && !p_rst) begin
      last_rst_len <= rst_low;
      rst_low      <= 0;
      t_rst_rise   <= cyc;
    end
    if (lcd_sclk && (lcd_sdo !== p_sdo)) edge_bad <= edge_bad + 1;
    if (!lcd_cs_n && p_cs) begin
      w_fall[nw] <= cyc;
      nbits      <= 0;
    end
    if (!lcd_cs_n && lcd_sclk && !p_sclk) begin
      shreg <= {shreg[7:0], lcd_sdo};
      nbits <= nbits + 1;
    end
    if (lcd_cs_n && !p_cs) begin
      w_val[nw]  <= shreg;
      w_bits[nw] <= nbits;
      w_rise[nw] <= cyc;
      nw         <= nw + 1;
    end
    p_cs   <= lcd_cs_n;
    p_sclk <= lcd_sclk;
    p_sdo  <= lcd_sdo;
    p_rst  <= lcd_rst_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit s, input bit e, input bit d, input bit o);
    @(negedge clk);
    start = s; en_req = e; dis_req = d; off_req = o;
    @(negedge clk);
    start = 0; en_req = 0; dis_req = 0; off_req = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lcd_cs_n && !lcd_sclk && lcd_rst_n, "R1 serial/reset pins", {lcd_cs_n, lcd_sclk, lcd_rst_n}, 3'b101);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);

    // R7 requests before start
    pulse(0, 1, 1, 1);
    repeat (20) @(negedge clk);
    chk(nw == 0 && !busy, "R7 request before start", nw, 0);

    // power-up with requests sprinkled in
    pulse(1, 0, 0, 0);
    repeat (NPULS + 20) @(negedge clk);
    pulse(1, 1, 1, 0);
    repeat (NSETT) @(negedge clk);
    pulse(0, 1, 0, 1);
    settle();

    chk(last_rst_len == NPULS, "R2 reset pulse length", last_rst_len, NPULS);
    chk(w_fall[0] - t_rst_rise >= NSETT, "R2 settle wait", w_fall[0] - t_rst_rise, NSETT);
    chk(nw == NINIT, "R7 word count during init", nw, NINIT);
    chk(w_val[0] == 9'h011, "R4 wake word", w_val[0], 9'h011);
    chk(w_fall[1] - w_rise[0] >= NWAKE, "R4 wake wait", w_fall[1] - w_rise[0], NWAKE);
    for (int i = 1; i < NINIT; i++)
      chk(w_val[i] == EXP[i], $sformatf("R5 script word %0d", i), w_val[i], EXP[i]);
    begin
      int badb = 0;
      for (int i = 0; i < nw; i++) if (w_bits[i] != 9) badb++;
      chk(badb == 0, "R3 nine clocks per word", badb, 0);
    end
    chk(edge_bad == 0, "R3 data stable while clock high", edge_bad, 0);
    chk(done && !busy, "R6 done after script", {done, busy}, 2'b10);

    // R8 single requests
    pulse(0, 1, 0, 0);
    settle();
    chk(nw == NINIT + 1 && w_val[nw-1] == 9'h029, "R8 display on", w_val[nw-1], 9'h029);
    pulse(0, 0, 1, 0);
    settle();
    chk(nw == NINIT + 2 && w_val[nw-1] == 9'h028, "R8 display off", w_val[nw-1], 9'h028);
    chk(done, "R8 done held", done, 1);

    // R10 priority
    pulse(0, 1, 1, 0);
    settle();
    chk(nw == NINIT + 3 && w_val[nw-1] == 9'h028, "R10 disable over enable", w_val[nw-1], 9'h028);
    pulse(0, 1, 1, 1);
    settle();
    chk(nw == NINIT + 4 && w_val[nw-1] == 9'h010, "R10 shutdown wins", w_val[nw-1], 9'h010);
    chk(!done, "R9 done falls after sleep", done, 0);

    // R9 requests after shutdown
    pulse(0, 1, 0, 0);
    repeat (30) @(negedge clk);
    chk(nw == NINIT + 4 && !busy, "R9 enable after shutdown ignored", nw, NINIT + 4);

    // R9 restart
    base = nw;
    pulse(1, 0, 0, 0);
    settle();
    chk(last_rst_len == NPULS, "R9 restart reset pulse", last_rst_len, NPULS);
    chk(nw - base == NINIT && w_val[base] == 9'h011, "R9 restart sequence", nw - base, NINIT);
    chk(done && edge_bad == 0, "R9 restart done", done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule